// File: doc/BRIEF.md
# Message Queue Unit

The unit passes 32-bit messages between two agents through four circular lists held in internal memory. A host register bus and a local register bus each see two port registers: an inbound port and an outbound port. A write to a port appends its data to one list. A read from the same port removes the oldest entry of a different list. Each list is therefore filled from one bus and drained from the other, so the two agents can exchange message frames or free-buffer tokens in both directions.

A control register on the host bus holds an enable bit, a 3-bit capacity code and four sticky overflow flags. While the unit is disabled, port accesses still complete, but they touch no list. The storage built per list is a synthesis parameter, and the capacity code can only lower the usable capacity below it. Every access completes in a single cycle. Read data returns on the cycle after the request.

Top module: `msgq_unit`

## Requirements
- R1: After reset the enable bit, the capacity code and all overflow flags are 0, so a host read of the control register (offset 00h) returns 00000000h, and every list is empty.
- R2: While enabled, a host write to offset 40h appends to the inbound-post list, and local reads of 40h return its entries oldest first.
- R3: While enabled, a local write to offset 40h appends to the inbound-free list, and a host read of 40h removes and returns its oldest entry.
- R4: While enabled, a host write to 44h appends to the outbound-free list, which local reads of 44h drain. A local write to 44h appends to the outbound-post list, which host reads of 44h drain.
- R5: While the enable bit (control bit 0) is 0, port writes are discarded and port reads return FFFFFFFFh, and no list gains or loses an entry.
- R6: A read of a port whose list is empty returns FFFFFFFFh and leaves that list unchanged.
- R7: List capacity is 256 shifted left by the capacity code (control bits 6:4), limited to the built storage 2**ADDR_W. A write to a full list is dropped and sets that list's sticky overflow flag: bit 8 inbound-post, bit 9 inbound-free, bit 10 outbound-free, bit 11 outbound-post. Writing 1 to a flag bit clears it.
- R8: A control write updates the capacity code only if the unit was disabled before that write. A code that differs from the current one empties all four lists and clears all overflow flags.
- R9: Head and tail pointers wrap modulo the capacity, so first-in first-out order holds across the wrap.
- R10: A write to a list on one bus and a read of that list on the other bus in the same cycle are both served. A read of an empty list returns FFFFFFFFh, and a write to a full list is dropped.
- R11: A read request is answered one cycle later with a one-cycle read-valid pulse. Offsets other than 00h, 40h and 44h read as 0 and ignore writes. On the local bus, 00h also reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_addr | input | 8 | Host byte offset |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read data valid |
| h_rdata | output | 32 | Host read data |
| l_req | input | 1 | Local access strobe |
| l_we | input | 1 | Local write (1) or read (0) |
| l_addr | input | 8 | Local byte offset |
| l_wdata | input | 32 | Local write data |
| l_rvalid | output | 1 | Local read data valid |
| l_rdata | output | 32 | Local read data |

## Verification
A single list can receive an append from one bus and a removal from the other bus in the same cycle. The bench provokes this by driving both buses at the same clock edge against the inbound-post list in three states: holding one entry, empty and full. With one entry held, the read must return that entry and the new data must come out next. When the list is empty, the read must return FFFFFFFFh while the write still lands. When the list is full, the read must succeed while the write is dropped and overflow bit 8 rises; the bench then drains the list to confirm its contents.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_IN   = 8'h40;
  localparam logic [7:0] OFS_OUT  = 8'h44;
  localparam int         NLISTS   = 4;
  localparam int         BASE_LOG2 = 8;

  typedef enum logic [1:0] {
    RD_ZERO = 2'd0,
    RD_CTRL = 2'd1,
    RD_ONES = 2'd2,
    RD_LIST = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/msgq_list.sv
module msgq_list #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [ADDR_W:0]   cap,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_q,
  output logic              pop_miss_q,
  input  logic              ovf_clr,
  output logic              ovf
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] head, tail, wrap_mask;
  logic [ADDR_W:0]   count;
  logic              push_ok, pop_ok;

  assign wrap_mask = ADDR_W'(cap - 1'b1);
  assign push_ok   = push && (count != cap);
  assign pop_ok    = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push_ok) mem[tail] <= push_data;
    if (pop_ok)  pop_q <= mem[head];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      ovf        <= 1'b0;
      pop_miss_q <= 1'b0;
    end else begin
      if (pop) pop_miss_q <= !pop_ok;
      if (push_ok) tail <= (tail + 1'b1) & wrap_mask;
      if (pop_ok)  head <= (head + 1'b1) & wrap_mask;
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
      if (push && !push_ok) ovf <= 1'b1;
      else if (ovf_clr)     ovf <= 1'b0;
    end
  end

  // R7
  count_cap_chk: assert property (@(posedge clk) disable iff (rst)
    count <= cap);
  // R7
  full_push_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (push && count == cap && !clr) |=> ovf);
  // R6
  empty_pop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0 && !clr) |=> ($stable(head) && pop_miss_q));
endmodule

// File: rtl/msgq_rd_path.sv
module msgq_rd_path #(
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [7:0]  addr,
  input  logic        en,
  input  logic [31:0] ctrl_word,
  input  logic [31:0] q_in,
  input  logic        miss_in,
  input  logic [31:0] q_out,
  input  logic        miss_out,
  output logic        rvalid,
  output logic [31:0] rdata
);
  import msgq_pkg::*;

  rd_kind_e    kind_q;
  logic        sel_out_q;
  logic [31:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid    <= 1'b0;
      kind_q    <= RD_ZERO;
      sel_out_q <= 1'b0;
      ctrl_q    <= '0;
    end else begin
      rvalid <= req && !we;
      if (req && !we) begin
        ctrl_q    <= ctrl_word;
        sel_out_q <= (addr == OFS_OUT);
        if (addr == OFS_IN || addr == OFS_OUT) kind_q <= en ? RD_LIST : RD_ONES;
        else if (HAS_CTRL && addr == OFS_CTRL) kind_q <= RD_CTRL;
        else kind_q <= RD_ZERO;
      end
    end
  end

  always_comb begin
    case (kind_q)
      RD_CTRL: rdata = ctrl_q;
      RD_ONES: rdata = '1;
      RD_LIST: rdata = sel_out_q ? (miss_out ? '1 : q_out) : (miss_in ? '1 : q_in);
      default: rdata = '0;
    endcase
  end

  // R11
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid);
  // R11
  no_rvalid_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rvalid);
endmodule

// File: rtl/msgq_unit.sv
module msgq_unit #(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        h_req,
  input  logic        h_we,
  input  logic [7:0]  h_addr,
  input  logic [31:0] h_wdata,
  output logic        h_rvalid,
  output logic [31:0] h_rdata,
  input  logic        l_req,
  input  logic        l_we,
  input  logic [7:0]  l_addr,
  input  logic [31:0] l_wdata,
  output logic        l_rvalid,
  output logic [31:0] l_rdata
);
  import msgq_pkg::*;

  logic                en_q, clr;
  logic [2:0]          size_q;
  logic [3:0]          ovf, ovf_clr;
  logic [ADDR_W:0]     cap;
  logic [NLISTS-1:0]   push, pop, miss;
  logic [31:0]         q [NLISTS];
  logic [31:0]         ctrl_word;
  logic                ctrl_wr;
  int unsigned         cap_log2;

  assign ctrl_wr = h_req && h_we && (h_addr == OFS_CTRL);
  assign clr     = ctrl_wr && !en_q && (h_wdata[6:4] != size_q);
  assign ovf_clr = ctrl_wr ? h_wdata[11:8] : 4'b0;

  always_comb begin
    cap_log2 = BASE_LOG2 + int'(size_q);
    if (cap_log2 > ADDR_W) cap_log2 = ADDR_W;
    cap = (ADDR_W+1)'(1) << cap_log2;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      size_q <= 3'd0;
    end else if (ctrl_wr) begin
      en_q <= h_wdata[0];
      if (!en_q) size_q <= h_wdata[6:4];
    end
  end

  assign ctrl_word = {20'b0, ovf, 1'b0, size_q, 3'b0, en_q};

  // list 0 inbound-post, 1 inbound-free, 2 outbound-free, 3 outbound-post
  // even lists are written by the host and drained by the local bus
  genvar gi;
  generate
    for (gi = 0; gi < NLISTS; gi++) begin : g_list
      localparam logic [7:0] OFS = (gi < 2) ? OFS_IN : OFS_OUT;
      logic        wr_req, rd_req;
      logic [31:0] wdata;
      if (gi % 2 == 0) begin : g_host_wr
        assign wr_req = h_req && h_we && (h_addr == OFS);
        assign rd_req = l_req && !l_we && (l_addr == OFS);
        assign wdata  = h_wdata;
      end else begin : g_local_wr
        assign wr_req = l_req && l_we && (l_addr == OFS);
        assign rd_req = h_req && !h_we && (h_addr == OFS);
        assign wdata  = l_wdata;
      end
      assign push[gi] = en_q && wr_req;
      assign pop[gi]  = en_q && rd_req;

      msgq_list #(.ADDR_W(ADDR_W), .DATA_W(32)) list_i (
        .clk(clk), .rst(rst), .clr(clr), .cap(cap),
        .push(push[gi]), .push_data(wdata),
        .pop(pop[gi]), .pop_q(q[gi]), .pop_miss_q(miss[gi]),
        .ovf_clr(ovf_clr[gi]), .ovf(ovf[gi])
      );
    end
  endgenerate

  msgq_rd_path #(.HAS_CTRL(1'b1)) host_rd_i (
    .clk(clk), .rst(rst), .req(h_req), .we(h_we), .addr(h_addr), .en(en_q),
    .ctrl_word(ctrl_word), .q_in(q[1]), .miss_in(miss[1]),
    .q_out(q[3]), .miss_out(miss[3]), .rvalid(h_rvalid), .rdata(h_rdata)
  );

  msgq_rd_path #(.HAS_CTRL(1'b0)) local_rd_i (
    .clk(clk), .rst(rst), .req(l_req), .we(l_we), .addr(l_addr), .en(en_q),
    .ctrl_word(32'b0), .q_in(q[0]), .miss_in(miss[0]),
    .q_out(q[2]), .miss_out(miss[2]), .rvalid(l_rvalid), .rdata(l_rdata)
  );

  initial begin
    if (ADDR_W < BASE_LOG2) $error("ADDR_W must be at least %0d", BASE_LOG2);
  end

  // R8
  size_lock_chk: assert property (@(posedge clk) disable iff (rst)
    en_q |=> (size_q == $past(size_q)));
  // R5
  disabled_no_access_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (push == '0 && pop == '0));
endmodule

// File: tb/msgq_unit_tb.sv
module msgq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_req = 0, h_we = 0, l_req = 0, l_we = 0;
  logic [7:0]  h_addr = 0, l_addr = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic        h_rvalid, l_rvalid;
  logic [31:0] h_rdata, l_rdata;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  msgq_unit #(.ADDR_W(9)) dut_i (.*);

  // {local, write, addr, wdata, expected, req}
  localparam int NV = 14;
  localparam logic [81:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h00, 32'h0000_0001, 32'h0, 8'd2},        // R2 enable
    {1'b0, 1'b1, 8'h40, 32'h1111_0001, 32'h0, 8'd2},        // R2
    {1'b0, 1'b1, 8'h40, 32'h1111_0002, 32'h0, 8'd2},        // R2
    {1'b1, 1'b0, 8'h40, 32'h0, 32'h1111_0001, 8'd2},        // R2
    {1'b1, 1'b0, 8'h40, 32'h0, 32'h1111_0002, 8'd2},        // R2
    {1'b1, 1'b0, 8'h40, 32'h0, 32'hFFFF_FFFF, 8'd6},        // R6
    {1'b1, 1'b1, 8'h40, 32'h2222_0001, 32'h0, 8'd3},        // R3
    {1'b0, 1'b0, 8'h40, 32'h0, 32'h2222_0001, 8'd3},        // R3
    {1'b0, 1'b1, 8'h44, 32'h3333_0001, 32'h0, 8'd4},        // R4
    {1'b1, 1'b0, 8'h44, 32'h0, 32'h3333_0001, 8'd4},        // R4
    {1'b1, 1'b1, 8'h44, 32'h4444_0001, 32'h0, 8'd4},        // R4
    {1'b0, 1'b0, 8'h44, 32'h0, 32'h4444_0001, 8'd4},        // R4
    {1'b0, 1'b0, 8'h48, 32'h0, 32'h0000_0000, 8'd11},       // R11
    {1'b1, 1'b0, 8'h00, 32'h0, 32'h0000_0000, 8'd11}        // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit lcl, input bit we, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] rd, output logic rv);
    @(negedge clk);
    if (lcl) begin l_req = 1; l_we = we; l_addr = a; l_wdata = d; end
    else     begin h_req = 1; h_we = we; h_addr = a; h_wdata = d; end
    @(negedge clk);
    h_req = 0; l_req = 0;
    rd = lcl ? l_rdata : h_rdata;
    rv = lcl ? l_rvalid : h_rvalid;
  endtask

  task automatic wr(input bit lcl, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic rv;
    acc(lcl, 1'b1, a, d, rd, rv);
  endtask

  task automatic rd_chk(input bit lcl, input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] rd; logic rv;
    acc(lcl, 1'b0, a, 32'h0, rd, rv);
    check(tag, rd, exp);
  endtask

  // both buses at the same edge: host writes 40h, local reads 40h
  task automatic dual(input logic [31:0] d, input logic [31:0] exp, input string tag);
    @(negedge clk);
    h_req = 1; h_we = 1; h_addr = 8'h40; h_wdata = d;
    l_req = 1; l_we = 0; l_addr = 8'h40;
    @(negedge clk);
    h_req = 0; l_req = 0;
    check(tag, l_rdata, exp);
  endtask

  initial begin
    logic [31:0] rd; logic rv;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_chk(0, 8'h00, 32'h0, "R1 control after reset");
    // R11 valid pulse
    acc(0, 1'b0, 8'h00, 32'h0, rd, rv);
    check("R11 rvalid on read", {31'b0, rv}, 32'h1);
    @(negedge clk);
    check("R11 rvalid drops", {31'b0, h_rvalid}, 32'h0);
    // R5 disabled at reset
    wr(0, 8'h40, 32'hDEAD_0001);
    rd_chk(1, 8'h40, 32'hFFFF_FFFF, "R5 disabled read");

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v = VEC[i];
      acc(v[81], v[80], v[79:72], v[71:40], rd, rv);
      if (!v[80]) begin
        checks++;
        if (rd !== v[39:8]) begin
          errors++;
          $display("FAIL R%0d vector %0d: got %08h expected %08h", v[7:0], i, rd, v[39:8]);
        end
      end
    end
    // R5 discarded write left nothing: list was empty after vectors
    rd_chk(1, 8'h40, 32'hFFFF_FFFF, "R5 disabled write discarded");

    // R5 pointers unchanged while disabled
    wr(1, 8'h40, 32'h5555_0001);
    wr(0, 8'h00, 32'h0);
    rd_chk(0, 8'h40, 32'hFFFF_FFFF, "R5 disabled read ones");
    wr(1, 8'h40, 32'h5555_0002);
    wr(0, 8'h00, 32'h1);
    rd_chk(0, 8'h40, 32'h5555_0001, "R5 entry kept");
    rd_chk(0, 8'h40, 32'hFFFF_FFFF, "R5 disabled write dropped");

    // R8 size ignored while enabled
    wr(0, 8'h00, 32'h0000_0011);
    rd_chk(0, 8'h00, 32'h0000_0001, "R8 size locked while enabled");

    // R7 capacity 256 at code 0, overflow flag
    for (int i = 0; i < 257; i++) wr(0, 8'h40, 32'hA000_0000 + i);
    rd_chk(0, 8'h00, 32'h0000_0101, "R7 overflow bit 8");
    wr(0, 8'h00, 32'h0000_0101);
    rd_chk(0, 8'h00, 32'h0000_0001, "R7 overflow cleared");
    // R10 full list: pop served, push dropped
    dual(32'hBBBB_0000, 32'hA000_0000, "R10 full dual read");
    rd_chk(0, 8'h00, 32'h0000_0101, "R10 full dual overflow");
    for (int i = 1; i < 256; i++) begin
      acc(1, 1'b0, 8'h40, 32'h0, rd, rv);
      if (i == 1 || i == 255) check("R9 drain order", rd, 32'hA000_0000 + i);
    end
    rd_chk(1, 8'h40, 32'hFFFF_FFFF, "R7 full write dropped");
    // R9 wrap: pointers now at 0 after full cycle; go across once more
    for (int i = 0; i < 200; i++) begin
      wr(0, 8'h40, 32'hC000_0000 + i);
      acc(1, 1'b0, 8'h40, 32'h0, rd, rv);
      if (i == 0 || i == 199) check("R9 across wrap", rd, 32'hC000_0000 + i);
    end
    // R10 one entry held, and empty list
    wr(0, 8'h40, 32'hD000_0001);
    dual(32'hD000_0002, 32'hD000_0001, "R10 dual with one entry");
    rd_chk(1, 8'h40, 32'hD000_0002, "R10 dual write landed");
    dual(32'hD000_0003, 32'hFFFF_FFFF, "R10 dual on empty");
    rd_chk(1, 8'h40, 32'hD000_0003, "R10 empty dual write landed");

    // R8 size change while disabled clears lists and flags
    wr(0, 8'h40, 32'hE000_0001);
    wr(0, 8'h00, 32'h0);
    wr(0, 8'h00, 32'h0000_0010);
    wr(0, 8'h00, 32'h0000_0011);
    rd_chk(0, 8'h00, 32'h0000_0011, "R8 size and flags after change");
    rd_chk(1, 8'h40, 32'hFFFF_FFFF, "R8 lists cleared");
    // R7 capacity 512 at code 1
    for (int i = 0; i < 512; i++) wr(1, 8'h44, 32'hF000_0000 + i);
    rd_chk(0, 8'h00, 32'h0000_0011, "R7 512 entries fit");
    wr(1, 8'h44, 32'hF000_FFFF);
    rd_chk(0, 8'h00, 32'h0000_0811, "R7 overflow bit 11");
    rd_chk(0, 8'h44, 32'hF000_0000, "R7 oldest kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule